// File: doc/BRIEF.md
# Micro-op Node Builder

This block turns a stream of micro-op timing records into a stream of weighted nodes for a behavioural core model. Each input beat carries one micro-op with three timestamps taken from two runs of the same program: the retirement time seen when every uncore request finished at once, and the issue and completion times seen when every request was forced to take a very long time. A beat also carries a three-bit request-kind mask, which is zero for micro-ops that send no request, and a flag that marks the final micro-op of a trace.

A micro-op's dependency is found from timing alone. It is the youngest recent request micro-op that completed strictly before this micro-op issued. Every request micro-op opens a run and a new node. Each following non-request micro-op joins the node of the current run that has the same dependency, or it opens a new node. Every node keeps a count of its micro-ops and a weight, which is the sum of the retirement-time gaps it has taken in. When a run is closed, its nodes go out in creation order on a valid/ready output. A run is closed by the next request micro-op, by the end of the trace, or by the run's node table filling up. The input stalls while nodes are being drained.

Top module: `uop_node_builder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, the first node created gets ID 0 and the first micro-op's weight contribution is its retirement time minus 0.
- R2: A micro-op's dependency is the youngest of the last `HIST_DEPTH` request micro-ops whose completion time is strictly less than the micro-op's issue time. If there is none, the node has `out_has_dep` = 0 and `out_dep_id` = 0. Equal times do not count as a dependency.
- R3: Every micro-op with a nonzero `in_kind` opens a new node whose `out_kind` equals that mask (bit 0 instruction-side, bit 1 load, bit 2 store). Nodes opened by non-request micro-ops have `out_kind` = 0.
- R4: A non-request micro-op joins the node of the current run that has the same dependency (null matches null), including the run's request node. Otherwise it opens a new node. It never joins a node of an earlier run.
- R5: Adding a micro-op to a node raises its size by 1 and adds (this retirement time − previous accepted micro-op's retirement time) to its weight.
- R6: Node IDs come from one counter that steps by 1 per created node. A node's dependency ID is the ID of the node opened by its dependency request.
- R7: When a request micro-op is presented while the run holds nodes, `in_ready` stays 0 until all of those nodes have been emitted in creation order. The request is accepted after that.
- R8: A micro-op with `in_last` set is accepted, after which every node of the run is emitted. The request history and the previous retirement time are then cleared, so the next trace starts fresh.
- R9: A non-request micro-op that needs a new node while `RUN_NODES` nodes are held first causes them all to be emitted. It then opens its node in an empty table, and later micro-ops of that run cannot join the emitted nodes.
- R10: While `out_valid` is 1, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, the output record is held unchanged into the next cycle.
- R11: A request micro-op older than the last `HIST_DEPTH` requests is never found as a dependency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Micro-op beat valid |
| in_ready | output | 1 | Micro-op beat accepted this cycle when high with `in_valid` |
| in_rt | input | TS_W | Retirement time, zero-latency run |
| in_it | input | TS_W | Issue time, long-latency run |
| in_ct | input | TS_W | Completion time, long-latency run |
| in_kind | input | 3 | Request-kind mask; 0 for a non-request micro-op |
| in_last | input | 1 | Final micro-op of the trace |
| out_valid | output | 1 | Node record valid |
| out_ready | input | 1 | Sink takes the node record |
| out_id | output | ID_W | Node ID |
| out_size | output | SIZE_W | Micro-ops in the node |
| out_weight | output | WGT_W | Summed retirement-time gaps |
| out_has_dep | output | 1 | Node has a dependency node |
| out_dep_id | output | ID_W | Dependency node ID |
| out_kind | output | 3 | Request-kind mask of the node |

## Verification
The directed traces first replay a small two-run example. It separates joining the request node, opening a second node for a different dependency, and refusing to join the previous run's node. A second trace puts an equal completion and issue time next to an earlier qualifying request, so that the strict comparison and the youngest-first search can be checked on their own. A third trace pushes more requests than the history holds, which shows that an evicted request yields no dependency. A fourth trace fills the run table with four distinct dependency keys and forces an overflow drain. A backpressure pattern on `out_ready` runs throughout and checks the output hold and the input stall.

// File: rtl/unb_pkg.sv
package unb_pkg;
    localparam int KIND_W     = 3;
    localparam int KIND_INSTR = 0;
    localparam int KIND_LOAD  = 1;
    localparam int KIND_STORE = 2;

    typedef logic [KIND_W-1:0] kind_t;

    typedef enum logic {
        PH_TAKE  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;
endpackage

// File: rtl/uop_dep_hist.sv
module uop_dep_hist #(
    parameter int TS_W  = 32,
    parameter int ID_W  = 16,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push,
    input  logic [TS_W-1:0] push_ct,
    input  logic [ID_W-1:0] push_id,
    input  logic [TS_W-1:0] probe_it,
    output logic            hit,
    output logic [ID_W-1:0] hit_id
);
    typedef struct packed {
        logic [DEPTH-1:0]           vld;
        logic [DEPTH-1:0][TS_W-1:0] ct;
        logic [DEPTH-1:0][ID_W-1:0] id;
    } hist_t;

    hist_t st_d, st_q;
    logic [DEPTH-1:0] older_done;

    // entry 0 is the youngest request
    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.vld = '0;
        end else if (push) begin
            for (int i = DEPTH - 1; i >= 1; i--) begin
                st_d.vld[i] = st_q.vld[i-1];
                st_d.ct[i]  = st_q.ct[i-1];
                st_d.id[i]  = st_q.id[i-1];
            end
            st_d.vld[0] = 1'b1;
            st_d.ct[0]  = push_ct;
            st_d.id[0]  = push_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign older_done[g] = st_q.vld[g] && (st_q.ct[g] < probe_it);
        end
    endgenerate

    // youngest-first priority: the lowest index wins
    always_comb begin
        hit    = 1'b0;
        hit_id = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (older_done[i]) begin
                hit    = 1'b1;
                hit_id = st_q.id[i];
            end
        end
    end
endmodule

// File: rtl/uop_run_nodes.sv
module uop_run_nodes
    import unb_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int SIZE_W = 16,
    parameter int WGT_W  = 32,
    parameter int SLOTS  = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             alloc,
    input  logic [ID_W-1:0]  alloc_id,
    input  logic [WGT_W-1:0] alloc_weight,
    input  logic             alloc_has_dep,
    input  logic [ID_W-1:0]  alloc_dep_id,
    input  kind_t            alloc_kind,
    input  logic             join_en,
    input  logic [IDX_W-1:0] join_idx,
    input  logic [WGT_W-1:0] join_weight,
    input  logic             key_has_dep,
    input  logic [ID_W-1:0]  key_dep_id,
    output logic             match_hit,
    output logic [IDX_W-1:0] match_idx,
    output logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ID_W-1:0]  rd_id,
    output logic [SIZE_W-1:0] rd_size,
    output logic [WGT_W-1:0] rd_weight,
    output logic             rd_has_dep,
    output logic [ID_W-1:0]  rd_dep_id,
    output kind_t            rd_kind
);
    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [SLOTS-1:0][ID_W-1:0]   id;
        logic [SLOTS-1:0][SIZE_W-1:0] size;
        logic [SLOTS-1:0][WGT_W-1:0]  weight;
        logic [SLOTS-1:0]             has_dep;
        logic [SLOTS-1:0][ID_W-1:0]   dep;
        logic [SLOTS-1:0][KIND_W-1:0] kind;
    } tab_t;

    tab_t tab_d, tab_q;
    logic [SLOTS-1:0] same_key;
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = IDX_W'(tab_q.cnt);

    always_comb begin
        tab_d = tab_q;
        if (clear) begin
            tab_d.cnt = '0;
        end else if (alloc) begin
            tab_d.id[wr_idx]      = alloc_id;
            tab_d.size[wr_idx]    = SIZE_W'(1);
            tab_d.weight[wr_idx]  = alloc_weight;
            tab_d.has_dep[wr_idx] = alloc_has_dep;
            tab_d.dep[wr_idx]     = alloc_has_dep ? alloc_dep_id : '0;
            tab_d.kind[wr_idx]    = alloc_kind;
            tab_d.cnt             = tab_q.cnt + 1'b1;
        end else if (join_en) begin
            tab_d.size[join_idx]   = tab_q.size[join_idx] + 1'b1;
            tab_d.weight[join_idx] = tab_q.weight[join_idx] + join_weight;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_key
            assign same_key[g] = (CNT_W'(g) < tab_q.cnt)
                              && (tab_q.has_dep[g] == key_has_dep)
                              && (!key_has_dep || (tab_q.dep[g] == key_dep_id));
        end
    endgenerate

    always_comb begin
        match_hit = 1'b0;
        match_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (same_key[i]) begin
                match_hit = 1'b1;
                match_idx = IDX_W'(i);
            end
        end
    end

    assign count      = tab_q.cnt;
    assign rd_id      = tab_q.id[rd_idx];
    assign rd_size    = tab_q.size[rd_idx];
    assign rd_weight  = tab_q.weight[rd_idx];
    assign rd_has_dep = tab_q.has_dep[rd_idx];
    assign rd_dep_id  = tab_q.dep[rd_idx];
    assign rd_kind    = tab_q.kind[rd_idx];
endmodule

// File: rtl/uop_node_builder.sv
module uop_node_builder
    import unb_pkg::*;
#(
    parameter int TS_W       = 32,
    parameter int ID_W       = 16,
    parameter int SIZE_W     = 16,
    parameter int WGT_W      = 32,
    parameter int HIST_DEPTH = 4,
    parameter int RUN_NODES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TS_W-1:0]   in_rt,
    input  logic [TS_W-1:0]   in_it,
    input  logic [TS_W-1:0]   in_ct,
    input  logic [2:0]        in_kind,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ID_W-1:0]   out_id,
    output logic [SIZE_W-1:0] out_size,
    output logic [WGT_W-1:0]  out_weight,
    output logic              out_has_dep,
    output logic [ID_W-1:0]   out_dep_id,
    output logic [2:0]        out_kind
);
    localparam int IDX_W = (RUN_NODES > 1) ? $clog2(RUN_NODES) : 1;
    localparam int CNT_W = $clog2(RUN_NODES + 1);

    typedef struct packed {
        phase_e           phase;
        logic [ID_W-1:0]  next_id;
        logic [TS_W-1:0]  prev_rt;
        logic [IDX_W-1:0] rd_idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             dep_hit;
    logic [ID_W-1:0]  dep_id;
    logic             match_hit;
    logic [IDX_W-1:0] match_idx;
    logic [CNT_W-1:0] count;
    logic             is_req, grow, table_full, drain_first, take;
    logic             last_slot, drain_done;
    logic [TS_W-1:0]  rt_gap;
    logic [WGT_W-1:0] gap_w;
    kind_t            rd_kind;

    assign is_req      = |in_kind;
    assign grow        = is_req || !match_hit;
    assign table_full  = (count == CNT_W'(RUN_NODES));
    assign drain_first = (count != '0) && (is_req || (!match_hit && table_full));
    assign in_ready    = (ctl_q.phase == PH_TAKE) && !drain_first;
    assign take        = in_valid && in_ready;
    assign rt_gap      = in_rt - ctl_q.prev_rt;
    assign gap_w       = WGT_W'(rt_gap);
    assign out_valid   = (ctl_q.phase == PH_DRAIN);
    assign last_slot   = (ctl_q.rd_idx == IDX_W'(count - 1'b1));
    assign drain_done  = out_valid && out_ready && last_slot;
    assign out_kind    = rd_kind;

    uop_dep_hist #(
        .TS_W  (TS_W),
        .ID_W  (ID_W),
        .DEPTH (HIST_DEPTH)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take && in_last),
        .push     (take && is_req),
        .push_ct  (in_ct),
        .push_id  (ctl_q.next_id),
        .probe_it (in_it),
        .hit      (dep_hit),
        .hit_id   (dep_id)
    );

    uop_run_nodes #(
        .ID_W   (ID_W),
        .SIZE_W (SIZE_W),
        .WGT_W  (WGT_W),
        .SLOTS  (RUN_NODES)
    ) u_nodes (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (drain_done),
        .alloc         (take && grow),
        .alloc_id      (ctl_q.next_id),
        .alloc_weight  (gap_w),
        .alloc_has_dep (dep_hit),
        .alloc_dep_id  (dep_id),
        .alloc_kind    (kind_t'(in_kind)),
        .join_en       (take && !grow),
        .join_idx      (match_idx),
        .join_weight   (gap_w),
        .key_has_dep   (dep_hit),
        .key_dep_id    (dep_id),
        .match_hit     (match_hit),
        .match_idx     (match_idx),
        .count         (count),
        .rd_idx        (ctl_q.rd_idx),
        .rd_id         (out_id),
        .rd_size       (out_size),
        .rd_weight     (out_weight),
        .rd_has_dep    (out_has_dep),
        .rd_dep_id     (out_dep_id),
        .rd_kind       (rd_kind)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_TAKE: begin
                if (take) begin
                    if (grow) begin
                        ctl_d.next_id = ctl_q.next_id + 1'b1;
                    end
                    ctl_d.prev_rt = in_last ? '0 : in_rt;
                    if (in_last) begin
                        ctl_d.phase  = PH_DRAIN;
                        ctl_d.rd_idx = '0;
                    end
                end else if (in_valid && drain_first) begin
                    ctl_d.phase  = PH_DRAIN;
                    ctl_d.rd_idx = '0;
                end
            end
            PH_DRAIN: begin
                if (out_ready) begin
                    if (last_slot) begin
                        ctl_d.phase  = PH_TAKE;
                        ctl_d.rd_idx = '0;
                    end else begin
                        ctl_d.rd_idx = ctl_q.rd_idx + 1'b1;
                    end
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_TAKE, next_id: '0, prev_rt: '0, rd_idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/uop_node_builder_chk.sv
module uop_node_builder_chk #(
    parameter int ID_W   = 16,
    parameter int SIZE_W = 16,
    parameter int WGT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ID_W-1:0]   out_id,
    input logic [SIZE_W-1:0] out_size,
    input logic [WGT_W-1:0]  out_weight,
    input logic              out_has_dep,
    input logic [ID_W-1:0]   out_dep_id
);
    logic            seen_q;
    logic [ID_W-1:0] last_id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            last_id_q <= '0;
        end else if (out_valid && out_ready) begin
            seen_q    <= 1'b1;
            last_id_q <= out_id;
        end
    end

    // R10 / R7: input is held off while records are pending
    p_stall_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10: a refused record stays put
    p_hold_record_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_id)
                                       && $stable(out_size) && $stable(out_weight)));

    // R6: records leave in creation order with consecutive IDs
    p_id_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> (out_id == ID_W'(last_id_q + 1'b1)));

    // R5: every emitted node holds at least one micro-op
    p_size_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_size != '0));

    // R2: a node never depends on itself
    p_dep_not_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_dep) |-> (out_dep_id != out_id));
endmodule

bind uop_node_builder uop_node_builder_chk #(
    .ID_W   (ID_W),
    .SIZE_W (SIZE_W),
    .WGT_W  (WGT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_id      (out_id),
    .out_size    (out_size),
    .out_weight  (out_weight),
    .out_has_dep (out_has_dep),
    .out_dep_id  (out_dep_id)
);

// File: tb/uop_node_builder_test.sv
`timescale 1ns/1ps
module uop_node_builder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_rt = '0, in_it = '0, in_ct = '0;
    logic [2:0]  in_kind = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_id, out_size, out_dep_id;
    logic [31:0] out_weight;
    logic        out_has_dep;
    logic [2:0]  out_kind;

    int checks = 0, errors = 0;
    int cyc = 0;
    int c_n = 0, exp_idx = 0;
    int c_id[64], c_size[64], c_w[64], c_hd[64], c_dep[64], c_kind[64];
    int stall_err = 0, hold_err = 0, hold_seen = 0;
    bit hold_v = 1'b0;
    logic [15:0] h_id, h_size;
    logic [31:0] h_w;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    uop_node_builder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_rt(in_rt), .in_it(in_it), .in_ct(in_ct), .in_kind(in_kind), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_size(out_size),
        .out_weight(out_weight), .out_has_dep(out_has_dep), .out_dep_id(out_dep_id),
        .out_kind(out_kind)
    );

    // collector: backpressure pattern, hold and stall monitors
    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (hold_v) begin
                hold_seen = hold_seen + 1;
                if (!out_valid || out_id != h_id || out_size != h_size || out_weight != h_w)
                    hold_err = hold_err + 1;
            end
            out_ready = (cyc % 3) != 0;
            hold_v = out_valid && !out_ready;
            h_id = out_id; h_size = out_size; h_w = out_weight;
            if (out_valid && in_ready) stall_err = stall_err + 1;
            if (out_valid && out_ready && c_n < 64) begin
                c_id[c_n] = out_id; c_size[c_n] = out_size; c_w[c_n] = out_weight;
                c_hd[c_n] = out_has_dep; c_dep[c_n] = out_dep_id; c_kind[c_n] = out_kind;
                c_n = c_n + 1;
            end
        end
    end

    task automatic check(input string req, input bit ok, input string got, input string exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %s expected %s", req, got, exp);
        end
    endtask

    task automatic send(input int rt, input int it, input int ct, input int kind, input bit last);
        @(negedge clk);
        in_rt = rt; in_it = it; in_ct = ct; in_kind = kind[2:0]; in_last = last;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic expect_node(input string req, input int id, input int size, input int w,
                               input int hd, input int dep, input int kind);
        int t = 0;
        while (c_n <= exp_idx && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (c_n <= exp_idx) begin
            check(req, 1'b0, "no record", $sformatf("id=%0d", id));
        end else begin
            check(req, c_id[exp_idx] == id && c_size[exp_idx] == size && c_w[exp_idx] == w
                       && c_hd[exp_idx] == hd && c_dep[exp_idx] == dep && c_kind[exp_idx] == kind,
                  $sformatf("id=%0d size=%0d w=%0d hd=%0d dep=%0d kind=%0d", c_id[exp_idx],
                            c_size[exp_idx], c_w[exp_idx], c_hd[exp_idx], c_dep[exp_idx], c_kind[exp_idx]),
                  $sformatf("id=%0d size=%0d w=%0d hd=%0d dep=%0d kind=%0d", id, size, w, hd, dep, kind));
        end
        exp_idx++;
    endtask

    task automatic test_reset();
        check("R1 out_valid", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
        check("R1 in_ready", in_ready == 1'b1, $sformatf("%0b", in_ready), "1");
    endtask

    // two runs: join request node, split by dependency, no join to earlier run
    task automatic test_two_runs();
        send(10, 1, 1005, 2, 0);
        send(11, 2, 0, 0, 0);
        send(11, 1010, 0, 0, 0);
        send(12, 5, 0, 0, 0);
        send(12, 1012, 0, 0, 0);
        send(15, 1020, 2030, 4, 0);
        send(16, 6, 0, 0, 0);
        send(18, 2040, 0, 0, 1);
        expect_node("R1 R3 R5 first node", 0, 3, 12, 0, 0, 2);
        expect_node("R4 R2 split by dependency", 1, 2, 0, 1, 0, 0);
        expect_node("R7 R6 store request node", 2, 1, 3, 1, 0, 4);
        expect_node("R4 no join to earlier run", 3, 1, 1, 0, 0, 0);
        expect_node("R8 R2 last flush", 4, 1, 2, 1, 2, 0);
    endtask

    // strict comparison and youngest-first search; fresh prev time after last
    task automatic test_strict_youngest();
        send(5, 0, 100, 3, 0);
        send(7, 200, 300, 1, 0);
        send(9, 300, 0, 0, 0);
        send(10, 301, 0, 0, 1);
        expect_node("R8 R3 weight restarts", 5, 1, 5, 0, 0, 3);
        expect_node("R2 equal time skipped, join", 6, 2, 4, 1, 5, 1);
        expect_node("R2 youngest qualifying", 7, 1, 1, 1, 6, 0);
    endtask

    task automatic test_history_depth();
        send(1, 0, 10, 2, 0);
        for (int k = 2; k <= 5; k++) send(k, 0, 5000, 2, 0);
        send(6, 20, 0, 0, 1);
        for (int k = 8; k <= 11; k++) expect_node("R11 request nodes", k, 1, 1, 0, 0, 2);
        expect_node("R11 evicted request not found", 12, 2, 2, 0, 0, 2);
    endtask

    task automatic test_overflow();
        send(1, 0, 10, 2, 0);
        send(2, 0, 20, 2, 0);
        send(3, 0, 30, 2, 0);
        send(4, 0, 40, 2, 0);
        send(5, 15, 0, 0, 0);
        send(6, 25, 0, 0, 0);
        send(7, 35, 0, 0, 0);
        send(8, 2, 0, 0, 0);
        send(10, 45, 0, 0, 0);
        send(11, 16, 0, 0, 1);
        expect_node("R9 req a", 13, 1, 1, 0, 0, 2);
        expect_node("R9 req b", 14, 1, 1, 0, 0, 2);
        expect_node("R9 req c", 15, 1, 1, 0, 0, 2);
        expect_node("R4 join while full", 16, 2, 2, 0, 0, 2);
        expect_node("R9 slot dep13", 17, 1, 1, 1, 13, 0);
        expect_node("R9 slot dep14", 18, 1, 1, 1, 14, 0);
        expect_node("R9 slot dep15", 19, 1, 1, 1, 15, 0);
        expect_node("R9 node after overflow", 20, 1, 2, 1, 16, 0);
        expect_node("R9 no join to drained node", 21, 1, 1, 1, 13, 0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1'b0, "timeout", "completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        test_reset();
        test_two_runs();
        test_strict_youngest();
        test_history_depth();
        test_overflow();
        repeat (5) @(negedge clk);
        check("R10 R7 input stalled during drain", stall_err == 0, $sformatf("%0d", stall_err), "0");
        check("R10 refused record held", hold_err == 0 && hold_seen > 0,
              $sformatf("err=%0d seen=%0d", hold_err, hold_seen), "err=0 seen>0");
        check("R6 no extra records", c_n == exp_idx, $sformatf("%0d", c_n), $sformatf("%0d", exp_idx));
        finish_up();
    end
endmodule